// File: doc/BRIEF.md
# Radix-4 CORDIC Vector Rotator

This block turns a two-dimensional vector through a signed angle using shift-and-add micro-rotations. Each micro-rotation works on a power of four rather than a power of two, so it settles an output word in about half as many steps as the binary form. At iteration `i` (counting from 1) the residual angle picks a signed digit from −2 to +2. The vector is then moved by that digit times `4^-i` of the other coordinate, and the residual loses the matching elementary angle `atan(d·4^-i)`.

The vector length grows by `sqrt(1 + d²·4^-2i)` at each step, and that growth depends on which digits were picked. The block therefore keeps a running reciprocal gain, updating it from a per-iteration table whenever a non-zero digit is applied. It applies this gain to both coordinates with one shared fixed-point multiplier before it raises `done`. A caller pulses `start` with the vector and the angle, then waits for the one-cycle `done` pulse. The rotated coordinates stay on the outputs until the next result.

Top module: `cordic4_rot`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `x_out` and `y_out` are 0 until the first result.
- R2: `done` is a pulse one cycle wide. It appears N+2 clock edges (10 with defaults) after the edge that accepts `start`.
- R3: Vector ports are two's complement, 16 bits wide, with 14 fraction bits. `angle_in` is two's complement radians with 14 fraction bits, and a positive angle turns counter-clockwise. For |angle| ≤ 0.6 rad and an input length ≤ 1.0, each output lies within 3 LSB of x·cosθ − y·sinθ and x·sinθ + y·cosθ.
- R4: Angles at the digit decision points (±0.125 rad and ±0.375 rad) and at the range limit (±0.6 rad) still meet the R3 tolerance. This holds where digits of magnitude two alter the gain.
- R5: A `start` pulse that arrives while a rotation is in progress, including the final scaling cycles, is ignored. The running result, its timing and the outputs are unaffected, and no extra `done` follows.
- R6: `x_out` and `y_out` change only on the cycle in which `done` is high. Between results they hold, including during a following rotation.
- R7: A zero angle returns the input vector exactly, bit for bit.
- R8: A `start` pulse given in the very cycle that `done` is high is accepted. It produces a correct result N+2 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a rotation when the unit is idle |
| x_in | input | 16 | Input x coordinate, Q2.14 |
| y_in | input | 16 | Input y coordinate, Q2.14 |
| angle_in | input | 16 | Rotation angle in radians, Q2.14 |
| done | output | 1 | One-cycle pulse marking a new result |
| x_out | output | 16 | Rotated x coordinate, Q2.14 |
| y_out | output | 16 | Rotated y coordinate, Q2.14 |

## Verification
Two things can fall on the same cycle: the result of one rotation is published, and the next rotation is accepted. The bench provokes this by driving `start` with a fresh operand on the cycle it sees `done` high. It then judges both rotations against the trigonometric reference. It also checks that the first result stays on the outputs until the second `done`, and that the second latency is still N+2. A related collision is a `start` that lands in the final scaling cycle of a running rotation. That pulse must be dropped without disturbing the result in flight.

// File: rtl/cordic4_pkg.sv
package cordic4_pkg;

    // Sequencer phases of the rotator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_SCX  = 2'd2,
        ST_SCY  = 2'd3
    } st_e;

endpackage

// File: rtl/cordic4_digit.sv
// Picks the signed radix-4 digit from the residual angle.
module cordic4_digit #(
    parameter int ZI = 20,
    parameter int FZ = 18,
    parameter int IT = 4
) (
    input  logic signed [ZI-1:0] z,
    input  logic [IT-1:0]        iter,
    output logic signed [2:0]    dsel
);
    localparam int TW = $clog2(FZ + 1);

    logic [TW-1:0]        tsh;
    logic signed [ZI-1:0] t_lo;
    logic signed [ZI-1:0] t_hi;

    always_comb begin
        // thresholds 0.5*4^-i and 1.5*4^-i
        tsh  = TW'(FZ - 1) - TW'({iter, 1'b0});
        t_lo = ZI'(1) << tsh;
        t_hi = ZI'(3) << tsh;
        if (z >= t_hi)       dsel = 3'sd2;
        else if (z >= t_lo)  dsel = 3'sd1;
        else if (z > -t_lo)  dsel = 3'sd0;
        else if (z > -t_hi)  dsel = -3'sd1;
        else                 dsel = -3'sd2;
    end
endmodule

// File: rtl/cordic4_rom.sv
// Elementary angles and gain factors per iteration, computed at elaboration.
module cordic4_rom #(
    parameter int N  = 8,
    parameter int FZ = 18,
    parameter int ZI = 20,
    parameter int KF = 20,
    parameter int KW = 21,
    parameter int IT = 4
) (
    input  logic [IT-1:0]        iter,
    input  logic                 mag2,
    output logic signed [ZI-1:0] ang,
    output logic [KW-1:0]        kfac
);
    logic signed [ZI-1:0] a1_t [N];
    logic signed [ZI-1:0] a2_t [N];
    logic [KW-1:0]        k1_t [N];
    logic [KW-1:0]        k2_t [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        localparam real STEP = 1.0 / (4.0 ** (g + 1));
        assign a1_t[g] = ZI'($rtoi($atan(STEP) * (2.0 ** FZ) + 0.5));
        assign a2_t[g] = ZI'($rtoi($atan(2.0 * STEP) * (2.0 ** FZ) + 0.5));
        assign k1_t[g] = KW'($rtoi((2.0 ** KF) / $sqrt(1.0 + STEP * STEP) + 0.5));
        assign k2_t[g] = KW'($rtoi((2.0 ** KF) / $sqrt(1.0 + 4.0 * STEP * STEP) + 0.5));
    end

    always_comb begin
        ang  = mag2 ? a2_t[0] : a1_t[0];
        kfac = mag2 ? k2_t[0] : k1_t[0];
        for (int j = 1; j < N; j++) begin
            if (int'(iter) == j + 1) begin
                ang  = mag2 ? a2_t[j] : a1_t[j];
                kfac = mag2 ? k2_t[j] : k1_t[j];
            end
        end
    end
endmodule

// File: rtl/cordic4_mul.sv
// Shared signed-by-unsigned multiplier used for gain tracking and output scaling.
module cordic4_mul #(
    parameter int AW = 22,
    parameter int BW = 21
) (
    input  logic signed [AW-1:0] a,
    input  logic [BW-1:0]        b,
    output logic signed [AW+BW:0] p
);
    localparam int PW = AW + BW + 1;

    assign p = PW'(a) * PW'($signed({1'b0, b}));
endmodule

// File: rtl/cordic4_rot.sv
module cordic4_rot
    import cordic4_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int FA = 14,
    parameter int G  = 4,
    parameter int N  = 8,
    parameter int KF = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [AW-1:0] angle_in,
    output logic                 done,
    output logic signed [DW-1:0] x_out,
    output logic signed [DW-1:0] y_out
);
    localparam int IW = DW + G + 2;
    localparam int FZ = FA + G;
    localparam int ZI = AW + G;
    localparam int KW = KF + 1;
    localparam int IT = $clog2(N + 1);
    localparam int SW = $clog2(2 * N + 1);
    localparam int PW = IW + KW + 1;
    localparam int OS = KF + G;

    typedef struct packed {
        st_e                  st;
        logic [IT-1:0]        iter;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZI-1:0] z;
        logic [KW-1:0]        k;
        logic signed [DW-1:0] xs;
        logic signed [DW-1:0] xo;
        logic signed [DW-1:0] yo;
        logic                 done;
    } rot_t;

    rot_t r_d, r_q;

    logic signed [2:0]    dsel;
    logic                 mag2;
    logic signed [ZI-1:0] ang;
    logic [KW-1:0]        kfac;
    logic signed [IW-1:0] mul_a;
    logic [KW-1:0]        mul_b;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic [SW-1:0]        sh;
    logic signed [IW-1:0] xsh;
    logic signed [IW-1:0] ysh;

    assign mag2 = (dsel == 3'sd2) || (dsel == -3'sd2);

    cordic4_digit #(.ZI(ZI), .FZ(FZ), .IT(IT)) u_dig (
        .z(r_q.z), .iter(r_q.iter), .dsel(dsel)
    );

    cordic4_rom #(.N(N), .FZ(FZ), .ZI(ZI), .KF(KF), .KW(KW), .IT(IT)) u_rom (
        .iter(r_q.iter), .mag2(mag2), .ang(ang), .kfac(kfac)
    );

    cordic4_mul #(.AW(IW), .BW(KW)) u_mul (
        .a(mul_a), .b(mul_b), .p(prod)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        mul_a    = '0;
        mul_b    = '0;
        // |d| = 2 means one shift fewer than |d| = 1
        sh       = SW'({r_q.iter, 1'b0}) - SW'(mag2);
        xsh      = r_q.x >>> sh;
        ysh      = r_q.y >>> sh;
        rnd      = prod + (PW'(1) <<< (OS - 1));
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.x    = {{(IW-DW-G){x_in[DW-1]}}, x_in, {G{1'b0}}};
                    r_d.y    = {{(IW-DW-G){y_in[DW-1]}}, y_in, {G{1'b0}}};
                    r_d.z    = {angle_in, {G{1'b0}}};
                    r_d.k    = '0;
                    r_d.k[KF] = 1'b1;
                    r_d.iter = IT'(1);
                    r_d.st   = ST_ITER;
                end
            end
            ST_ITER: begin
                mul_a = IW'(r_q.k);
                mul_b = kfac;
                if (dsel > 3'sd0) begin
                    r_d.x = r_q.x - ysh;
                    r_d.y = r_q.y + xsh;
                    r_d.z = r_q.z - ang;
                    r_d.k = prod[KF +: KW];
                end else if (dsel < 3'sd0) begin
                    r_d.x = r_q.x + ysh;
                    r_d.y = r_q.y - xsh;
                    r_d.z = r_q.z + ang;
                    r_d.k = prod[KF +: KW];
                end
                if (r_q.iter == IT'(N)) r_d.st = ST_SCX;
                else                    r_d.iter = r_q.iter + IT'(1);
            end
            ST_SCX: begin
                mul_a  = r_q.x;
                mul_b  = r_q.k;
                r_d.xs = rnd[OS +: DW];
                r_d.st = ST_SCY;
            end
            ST_SCY: begin
                mul_a    = r_q.y;
                mul_b    = r_q.k;
                r_d.xo   = r_q.xs;
                r_d.yo   = rnd[OS +: DW];
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done  = r_q.done;
    assign x_out = r_q.xo;
    assign y_out = r_q.yo;
endmodule

// File: rtl/cordic4_rot_chk.sv
module cordic4_rot_chk
    import cordic4_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int IT = 4,
    parameter int ZI = 20,
    parameter int KW = 21,
    parameter int FZ = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic signed [DW-1:0] x_out,
    input logic signed [DW-1:0] y_out,
    input st_e                  st,
    input logic [IT-1:0]        iter,
    input logic signed [ZI-1:0] z,
    input logic [KW-1:0]        k
);
    localparam int ZB = 2 ** (FZ - 2 * N + 1);

    logic [7:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (st == ST_IDLE && start)   cnt <= '0;
        else if (cnt != 8'hFF)             cnt <= cnt + 8'd1;
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(cnt) == N + 2));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(x_out) && $stable(y_out)));

    assert_busy_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ITER && start) |=> (st == ST_SCX || iter == $past(iter) + IT'(1)));

    assert_gain_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ITER) |=> (k <= $past(k)));

    assert_residual_small_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCX) |-> ((z < ZB) && (z > -ZB)));
endmodule

bind cordic4_rot cordic4_rot_chk #(
    .N(N), .DW(DW), .IT(IT), .ZI(ZI), .KW(KW), .FZ(FZ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .x_out(x_out), .y_out(y_out),
    .st(r_q.st), .iter(r_q.iter), .z(r_q.z), .k(r_q.k)
);

// File: tb/sim_cordic4_rot.sv
module sim_cordic4_rot;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int LAT = N + 2;
    localparam int TOL = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [15:0] x_in = '0;
    logic signed [15:0] y_in = '0;
    logic signed [15:0] angle_in = '0;
    logic              done;
    logic signed [15:0] x_out;
    logic signed [15:0] y_out;

    int errs = 0;
    int checks = 0;

    cordic4_rot u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .angle_in(angle_in),
        .done(done), .x_out(x_out), .y_out(y_out)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd_i(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int ex_x(input int xv, input int yv, input int av);
        real th = av / 16384.0;
        return rnd_i(xv * $cos(th) - yv * $sin(th));
    endfunction

    function automatic int ex_y(input int xv, input int yv, input int av);
        real th = av / 16384.0;
        return rnd_i(xv * $sin(th) + yv * $cos(th));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Called on a falling edge; returns on the falling edge where done is seen.
    task automatic do_op(input int xv, input int yv, input int av, input int busy_at,
                         output int lat, output int xo, output int yo, output bit held);
        int hx = x_out;
        int hy = y_out;
        held = 1'b1;
        start = 1'b1; x_in = 16'(xv); y_in = 16'(yv); angle_in = 16'(av);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 60) begin
            if (x_out != 16'(hx) || y_out != 16'(hy)) held = 1'b0;
            @(negedge clk);
            lat++;
            start = (lat == busy_at);
            if (start) begin
                x_in = 16'sd7000; y_in = -16'sd9000; angle_in = 16'sd5000;
            end
        end
        start = 1'b0;
        xo = x_out;
        yo = y_out;
    endtask

    task automatic judge(input int xv, input int yv, input int av, input string tag);
        int lat, xo, yo, ex, ey;
        bit held;
        do_op(xv, yv, av, -1, lat, xo, yo, held);
        ex = ex_x(xv, yv, av);
        ey = ex_y(xv, yv, av);
        chk(lat == LAT, {tag, " latency (R2)"}, lat, LAT);
        chk(iabs(xo - ex) <= TOL, {tag, " x_out"}, xo, ex);
        chk(iabs(yo - ey) <= TOL, {tag, " y_out"}, yo, ey);
        @(negedge clk);
    endtask

    int vx[6] = '{16000, 0, -12000, 9000, -11585, 5};
    int vy[6] = '{0, 16000, 8000, -13000, -11585, -3};
    int edge_ang[9] = '{9830, -9830, 2048, -2048, 6144, -6144, 2047, 6143, -6145};

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog (R2) actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat, xo, yo, ex, ey;
        bit held;

        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done during reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(x_out == 0, "R1 x_out after reset", x_out, 0);
        chk(y_out == 0, "R1 y_out after reset", y_out, 0);

        // R7: zero angle is exact
        for (int v = 0; v < 6; v++) begin
            do_op(vx[v], vy[v], 0, -1, lat, xo, yo, held);
            chk(xo == vx[v], "R7 zero angle x", xo, vx[v]);
            chk(yo == vy[v], "R7 zero angle y", yo, vy[v]);
            @(negedge clk);
            chk(done == 1'b0, "R2 done one cycle", done, 0);
        end

        // R3: angle sweep over several vectors
        for (int v = 0; v < 6; v++)
            for (int a = -9800; a <= 9800; a += 400)
                judge(vx[v], vy[v], a, "R3 sweep");

        // R4: decision points and range limits
        for (int v = 0; v < 6; v++)
            for (int e = 0; e < 9; e++)
                judge(vx[v], vy[v], edge_ang[e], "R4 edge");

        // R5: start while busy, in iteration and in the last scaling cycle
        for (int b = 0; b < 3; b++) begin
            int bat = (b == 0) ? 2 : ((b == 1) ? 5 : LAT - 1);
            do_op(12000, -5000, 8000, bat, lat, xo, yo, held);
            ex = ex_x(12000, -5000, 8000);
            ey = ex_y(12000, -5000, 8000);
            chk(lat == LAT, "R5 busy start latency", lat, LAT);
            chk(iabs(xo - ex) <= TOL, "R5 busy start x_out", xo, ex);
            chk(iabs(yo - ey) <= TOL, "R5 busy start y_out", yo, ey);
            begin
                int extra = 0;
                for (int c = 0; c < LAT + 4; c++) begin
                    @(negedge clk);
                    if (done) extra++;
                end
                chk(extra == 0, "R5 no extra done", extra, 0);
            end
        end

        // R6: outputs hold while idle
        do_op(-7000, 10000, -4000, -1, lat, xo, yo, held);
        for (int c = 0; c < 20; c++) @(negedge clk);
        chk(x_out == 16'(xo), "R6 idle hold x", x_out, xo);
        chk(y_out == 16'(yo), "R6 idle hold y", y_out, yo);

        // R8: new start in the cycle done is high
        do_op(15000, 3000, 7000, -1, lat, xo, yo, held);
        for (int r = 0; r < 3; r++) begin
            int pxo = xo;
            int pyo = yo;
            int av = -9000 + r * 6500;
            do_op(-6000, 14000, av, -1, lat, xo, yo, held);
            ex = ex_x(-6000, 14000, av);
            ey = ex_y(-6000, 14000, av);
            chk(held, "R6 previous result held during next rotation", held, 1);
            chk(lat == LAT, "R8 back-to-back latency", lat, LAT);
            chk(iabs(xo - ex) <= TOL, "R8 back-to-back x_out", xo, ex);
            chk(iabs(yo - ey) <= TOL, "R8 back-to-back y_out", yo, ey);
            chk(pxo != xo || pyo != yo, "R8 new result published", xo, ex);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule